// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Front End

This block is the digital front end of a four-channel, 12-bit converter. A host processor writes codes over a bus that is either 12 or 8 bits wide. Each write lands in one of four staging registers, chosen by a 2-bit channel address. A separate commit strobe then copies all four staging registers into four output registers in the same cycle, so every channel changes together. The same commit strobe, paired with a clear request, sends every output register back to mid-scale. Power-on reset does the same.

Each output register also drives a segmented form for a resistor-ladder driver. Its top 3 bits become a 7-bit thermometer of equally weighted levels, and its low 9 bits pass through unchanged. All controls are active high and sampled on the rising clock edge. A write or a commit takes effect in the cycle it is presented. It cannot be held off, so the bus interface has no back-pressure and uses plain strobes rather than a valid/ready pair.

Top module: `quad_dac_frontend`

## Requirements
- R1: While `rst` is high, every staging register and every output register is set to 12'h800 (mid-scale). The outputs show 12'h800 from the first cycle after reset.
- R2: A staging register changes only when `bus_sel` and `load_stb` are both high at the clock edge.
- R3: With `wide_mode`=1, a write stores `bus_data[11:0]` unchanged into the staging register at index `bus_addr`.
- R4: With `wide_mode`=0 and `low_nib`=0, a write stores `bus_data[11:4]` into bits 11:4. It also copies `bus_data[11:8]` into bits 3:0, which gives an MSB-justified 8-bit interface.
- R5: With `wide_mode`=0 and `low_nib`=1, a write stores `bus_data[11:8]` into bits 3:0 and leaves bits 11:4 unchanged.
- R6: A write changes only the staging register selected by `bus_addr`. The other three keep their values.
- R7: When `commit_stb` and `commit_req` are both high and `clear_req` is low, all four output registers load their staging registers in that cycle. Without `commit_stb`, the output registers hold their values.
- R8: When `commit_stb` and `clear_req` are both high, all four output registers become 12'h800, whatever `commit_req` is. `clear_req` without `commit_stb` has no effect.
- R9: If a write and a transfer happen in the same cycle, the output registers take the staging contents from before that write.
- R10: Channel c drives `dac_therm[c*7 +: 7]`. Bit k of that slice is 1 exactly when the channel's code bits 11:9 exceed k, so the number of ones equals the 3-bit value.
- R11: Channel c drives `dac_low[c*9 +: 9]`, which equals bits 8:0 of that channel's output register. `dac_code[c*12 +: 12]` is that output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| bus_sel | input | 1 | Bus select for staging writes |
| load_stb | input | 1 | Staging write strobe |
| bus_addr | input | 2 | Channel index of the staging register |
| bus_data | input | 12 | Bus data; narrow mode uses bits 11:4 |
| wide_mode | input | 1 | 1 = 12-bit bus, 0 = 8-bit bus |
| low_nib | input | 1 | Narrow mode only: 1 = write only the low 4 bits |
| commit_stb | input | 1 | Strobe for transfer or clear |
| commit_req | input | 1 | Request a transfer of all channels |
| clear_req | input | 1 | Request a clear to mid-scale |
| dac_code | output | 48 | Four 12-bit output register values |
| dac_therm | output | 28 | Four 7-bit thermometer codes of bits 11:9 |
| dac_low | output | 36 | Four 9-bit low fields |

## Verification
The assertions check on every cycle that:
- the staging registers hold whenever no write is strobed;
- the output registers hold whenever no commit is strobed;
- a clear always yields mid-scale;
- a transfer copies the staging contents from the previous cycle;
- each thermometer has the right shape and the right count of ones.

Only the bench scenarios can show the data placement under the three write kinds, the per-channel addressing and the reset values. To do this they sweep every 12-bit code through the wide path and every byte and nibble through the narrow path, and compare against a bench-side model.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_FULL  = 2'd1,
    WK_UPPER = 2'd2,
    WK_LOWER = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/dacif_inbank.sv
module dacif_inbank
  import dacif_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int NB  = 8,
  localparam int AW = $clog2(NCH),
  localparam int FW = W - NB
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_kind_e         wkind,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     data,
  output logic [NCH*W-1:0] stage_flat
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0] stage_q;
    logic         hit;
    assign hit = (addr == AW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= MID;
      end else if (hit) begin
        case (wkind)
          WK_FULL:  stage_q <= data;
          WK_UPPER: stage_q <= {data[W-1:FW], data[W-1 -: FW]};
          WK_LOWER: stage_q[FW-1:0] <= data[W-1 -: FW];
          default:  stage_q <= stage_q;
        endcase
      end
    end
    assign stage_flat[g*W +: W] = stage_q;
  end
endmodule

// File: rtl/dacif_holdbank.sv
module dacif_holdbank #(
  parameter int NCH = 4,
  parameter int W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_clear,
  input  logic             do_xfer,
  input  logic [NCH*W-1:0] stage_flat,
  output logic [NCH*W-1:0] hold_flat
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst || do_clear) hold_q <= MID;
      else if (do_xfer)    hold_q <= stage_flat[g*W +: W];
    end
    assign hold_flat[g*W +: W] = hold_q;
  end
endmodule

// File: rtl/dacif_segenc.sv
module dacif_segenc #(
  parameter int W   = 12,
  parameter int SEG = 3,
  localparam int LOW = W - SEG,
  localparam int TH  = (1 << SEG) - 1
) (
  input  logic [W-1:0]   code,
  output logic [TH-1:0]  therm,
  output logic [LOW-1:0] low
);
  logic [SEG-1:0] top;
  assign top = code[W-1 -: SEG];
  assign low = code[LOW-1:0];

  for (genvar k = 0; k < TH; k++) begin : g_lvl
    assign therm[k] = (top > SEG'(k));
  end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import dacif_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int NB  = 8,
  parameter int SEG = 3,
  localparam int AW  = $clog2(NCH),
  localparam int LOW = W - SEG,
  localparam int TH  = (1 << SEG) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               load_stb,
  input  logic [AW-1:0]      bus_addr,
  input  logic [W-1:0]       bus_data,
  input  logic               wide_mode,
  input  logic               low_nib,
  input  logic               commit_stb,
  input  logic               commit_req,
  input  logic               clear_req,
  output logic [NCH*W-1:0]   dac_code,
  output logic [NCH*TH-1:0]  dac_therm,
  output logic [NCH*LOW-1:0] dac_low
);
  wr_kind_e           wkind;
  logic [NCH*W-1:0]   stage_flat;
  logic [NCH*W-1:0]   hold_flat;
  logic               do_clear;
  logic               do_xfer;

  always_comb begin
    if (!(bus_sel && load_stb)) wkind = WK_NONE;
    else if (wide_mode)         wkind = WK_FULL;
    else if (low_nib)           wkind = WK_LOWER;
    else                        wkind = WK_UPPER;
  end

  assign do_clear = commit_stb && clear_req;
  assign do_xfer  = commit_stb && commit_req;

  dacif_inbank #(.NCH(NCH), .W(W), .NB(NB)) u_in (
    .clk(clk), .rst(rst), .wkind(wkind), .addr(bus_addr),
    .data(bus_data), .stage_flat(stage_flat)
  );

  dacif_holdbank #(.NCH(NCH), .W(W)) u_hold (
    .clk(clk), .rst(rst), .do_clear(do_clear), .do_xfer(do_xfer),
    .stage_flat(stage_flat), .hold_flat(hold_flat)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_enc
    dacif_segenc #(.W(W), .SEG(SEG)) u_enc (
      .code(hold_flat[g*W +: W]),
      .therm(dac_therm[g*TH +: TH]),
      .low(dac_low[g*LOW +: LOW])
    );
  end

  assign dac_code = hold_flat;
endmodule

// File: rtl/quad_dac_frontend_chk.sv
module quad_dac_frontend_chk #(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int SEG = 3,
  localparam int LOW = W - SEG,
  localparam int TH  = (1 << SEG) - 1
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               load_stb,
  input logic               commit_stb,
  input logic               commit_req,
  input logic               clear_req,
  input logic [NCH*W-1:0]   stage_flat,
  input logic [NCH*W-1:0]   dac_code,
  input logic [NCH*TH-1:0]  dac_therm,
  input logic [NCH*LOW-1:0] dac_low
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  p_reset_mid_r1: assert property (@(posedge clk)
    rst |=> (dac_code == {NCH{MID}}));

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && load_stb) |=> $stable(stage_flat));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !commit_stb |=> $stable(dac_code));

  p_clear_mid_r8: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && clear_req) |=> (dac_code == {NCH{MID}}));

  p_xfer_old_r9: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && commit_req && !clear_req) |=> (dac_code == $past(stage_flat)));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [TH-1:0] t;
    logic [TH:0]   t_ext;
    assign t     = dac_therm[g*TH +: TH];
    assign t_ext = {1'b0, t} + 1'b1;

    p_therm_count_r10: assert property (@(posedge clk) disable iff (rst)
      $countones(t) == int'(dac_code[g*W + LOW +: SEG]));

    p_therm_shape_r10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(t_ext));

    p_low_pass_r11: assert property (@(posedge clk) disable iff (rst)
      dac_low[g*LOW +: LOW] == dac_code[g*W +: LOW]);
  end
endmodule

bind quad_dac_frontend quad_dac_frontend_chk #(.NCH(NCH), .W(W), .SEG(SEG)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .load_stb(load_stb),
  .commit_stb(commit_stb), .commit_req(commit_req), .clear_req(clear_req),
  .stage_flat(stage_flat), .dac_code(dac_code), .dac_therm(dac_therm),
  .dac_low(dac_low)
);

// File: tb/quad_dac_frontend_tb.sv
module quad_dac_frontend_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, load_stb, wide_mode, low_nib;
  logic [1:0]  bus_addr;
  logic [11:0] bus_data;
  logic        commit_stb, commit_req, clear_req;
  logic [47:0] dac_code;
  logic [27:0] dac_therm;
  logic [35:0] dac_low;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;
  logic [11:0] m_in  [4];
  logic [11:0] m_dac [4];

  always #2 clk = ~clk;

  quad_dac_frontend u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .load_stb(load_stb),
    .bus_addr(bus_addr), .bus_data(bus_data), .wide_mode(wide_mode),
    .low_nib(low_nib), .commit_stb(commit_stb), .commit_req(commit_req),
    .clear_req(clear_req), .dac_code(dac_code), .dac_therm(dac_therm),
    .dac_low(dac_low)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    bus_sel = 0; load_stb = 0; bus_addr = 0; bus_data = 0;
    wide_mode = 1; low_nib = 0;
    commit_stb = 0; commit_req = 0; clear_req = 0;
  endtask

  function automatic logic [6:0] therm_of(logic [2:0] v);
    logic [6:0] r = '0;
    for (int k = 0; k < 7; k++) r[k] = (k < int'(v));
    return r;
  endfunction

  task automatic model_write(int ch, logic [11:0] d, bit wide, bit lown);
    if (wide)      m_in[ch] = d;
    else if (lown) m_in[ch][3:0] = d[11:8];
    else           m_in[ch] = {d[11:4], d[11:8]};
  endtask

  task automatic wr(int ch, logic [11:0] d, bit wide, bit lown);
    bus_sel = 1; load_stb = 1; bus_addr = 2'(ch); bus_data = d;
    wide_mode = wide; low_nib = lown;
    model_write(ch, d, wide, lown);
    cyc();
    idle();
  endtask

  task automatic commit(bit stb, bit xf, bit clr);
    commit_stb = stb; commit_req = xf; clear_req = clr;
    if (stb && clr)     for (int c = 0; c < 4; c++) m_dac[c] = 12'h800;
    else if (stb && xf) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    cyc();
    idle();
  endtask

  task automatic check(string tag);
    for (int c = 0; c < 4; c++) begin
      checks++;
      if (dac_code[c*12 +: 12] !== m_dac[c]) begin
        fails++;
        $display("FAIL %s ch%0d code actual=%h expected=%h", tag, c, dac_code[c*12 +: 12], m_dac[c]);
      end
      checks++;
      if (dac_therm[c*7 +: 7] !== therm_of(m_dac[c][11:9])) begin
        fails++;
        $display("FAIL R10 (%s) ch%0d therm actual=%b expected=%b", tag, c,
                 dac_therm[c*7 +: 7], therm_of(m_dac[c][11:9]));
      end
      checks++;
      if (dac_low[c*9 +: 9] !== m_dac[c][8:0]) begin
        fails++;
        $display("FAIL R11 (%s) ch%0d low actual=%h expected=%h", tag, c, dac_low[c*9 +: 9], m_dac[c][8:0]);
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    for (int c = 0; c < 4; c++) begin m_in[c] = 12'h800; m_dac[c] = 12'h800; end
    repeat (3) cyc();
    rst = 0;
    cyc();
    check("R1 reset outputs");
    commit(1, 1, 0);
    check("R1 reset staging");

    // R2: incomplete write strobes leave staging untouched
    bus_sel = 0; load_stb = 1; bus_addr = 1; bus_data = 12'h123; cyc(); idle();
    bus_sel = 1; load_stb = 0; bus_addr = 2; bus_data = 12'h456; cyc(); idle();
    commit(1, 1, 0);
    check("R2 gated write");

    // R3/R6/R7: every 12-bit code through the wide path, rotating channels
    for (int v = 0; v < 4096; v++) begin
      wr(v % 4, 12'(v ^ 12'hA5C), 1, 0);
      commit(1, 1, 0);
      check("R3/R6 wide sweep");
    end

    // R4/R5: every byte through narrow upper writes, then a nibble
    for (int b = 0; b < 256; b++) begin
      wr(b % 4, {8'(b), 4'h0}, 0, 0);
      commit(1, 1, 0);
      check("R4 narrow upper");
      wr(b % 4, {4'(b ^ 5), 8'h00}, 0, 1);
      commit(1, 1, 0);
      check("R5 narrow lower");
    end

    // R7: no commit strobe means no change
    wr(0, 12'hFFF, 1, 0);
    wr(3, 12'h001, 1, 0);
    commit(0, 1, 0);
    check("R7 request without strobe");
    commit(1, 0, 0);
    check("R7 strobe without request");
    commit(1, 1, 0);
    check("R7 transfer");

    // R8: clear alone, clear with transfer, clear without strobe
    commit(0, 0, 1);
    check("R8 clear without strobe");
    commit(1, 1, 1);
    check("R8 clear priority");
    commit(1, 1, 0);
    check("R7 after clear");
    commit(1, 0, 1);
    check("R8 clear");

    // R9: write and transfer in the same cycle
    commit(1, 1, 0);
    bus_sel = 1; load_stb = 1; bus_addr = 2; bus_data = 12'h3C7; wide_mode = 1;
    commit_stb = 1; commit_req = 1;
    for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    model_write(2, 12'h3C7, 1, 0);
    cyc(); idle();
    check("R9 old contents");
    commit(1, 1, 0);
    check("R9 new contents next");

    finished = 1;
    summary();
    $finish;
  end
endmodule